// File: doc/BRIEF.md
# DMA Address Mode Classifier

This block looks at each incoming DMA request (a 64-bit virtual address, an 8-bit bus ID and a message-signalled-interrupt flag) and decides how the address must be handled. There are four outcomes. The request can pass straight through as a physical address (bypass). It can go to the legacy translation path. It can go to the table-based translation path. Or it is rejected as illegal. For table-based requests the block also selects which of up to 32 I/O translation tables the later walk must use. That table number is packed in byte lanes of sixteen mapping words, and the bus ID picks the lane.

A small register write port loads a control word and the sixteen mapping words. The results are registered and appear one clock after the request, together with a copy of the request valid. The block does no table walk and no memory access.

Top module: `dma_mode_classifier`

## Requirements
- R1: After a synchronous reset, all outputs are zero. The control word and all mapping words read as zero, so a request sent with no prior write is classified as an error.
- R2: A write with `wr_addr` = 0 loads the control word. Bit 0 enables translation, bit 1 enables bypass, bit 2 selects table-based mode (1) over legacy mode (0), and bit 3 selects the bus-ID bits used for the table index. A write with `wr_addr` = 16+k (k = 0..15) loads mapping word k.
- R3: A request is a bypass when address bits 63:39 equal 25'h1fff800 and either bypass is enabled or `msi` is 1. Its mode code is 1, and `pa` equals address bits 39:0.
- R4: A request that is not a bypass is legacy (mode code 2) when translation is enabled, table mode is off and address bits 63:32 are all zero.
- R5: A request that is neither bypass nor legacy is table-based (mode code 3) when translation is enabled, table mode is on and address bits 62:40 are all zero.
- R6: A valid request that matches none of R3 to R5 gives mode code 0 with `err` = 1. The checks are applied in the order bypass, legacy, table-based.
- R7: The 7-bit table index is {address bit 63, bus ID bits 5:0} when control bit 3 is 1, and {address bit 63, bus ID bits 6:1} when it is 0.
- R8: Index bits 6:3 pick the mapping word. Index bits 2:0 pick byte lane n. `tbl_num` is bits 8n+4 down to 8n of that word.
- R9: Outputs change on the clock edge that samples the request. `out_valid` equals the `in_valid` of the previous cycle. When `in_valid` was 0, every other output is 0.
- R10: `pa` is zero unless the mode is bypass, and `tbl_num` is zero unless the mode is table-based.
- R11: A request that arrives in the same cycle as a register write is classified with the register contents from before that write.
- R12: Writes to addresses 1 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 64 | Register write data |
| in_valid | input | 1 | Request valid |
| va | input | 64 | DMA virtual address |
| bus_id | input | 8 | Requester bus ID |
| msi | input | 1 | Request is a message-signalled interrupt |
| out_valid | output | 1 | Result valid, one cycle after the request |
| mode | output | 2 | 0 error, 1 bypass, 2 legacy, 3 table-based |
| pa | output | 40 | Bypass physical address |
| tbl_num | output | 5 | Selected translation-table number |
| err | output | 1 | Illegal address |

## Verification
A register write and a classification can happen in the same cycle. This matters most when the write retargets the control word or the mapping word that the pending lookup uses. The bench drives both together in directed cases and during random traffic. It computes the expected result from its shadow register copy before it applies the write to that copy, so any result that reflects the new value is reported.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    DMC_ERR    = 2'd0,
    DMC_BYPASS = 2'd1,
    DMC_LEGACY = 2'd2,
    DMC_TABLE  = 2'd3
  } dmc_mode_e;

  typedef struct packed {
    logic bus_sel;
    logic tbl_mode;
    logic byp_en;
    logic xlate_en;
  } dmc_ctrl_t;
endpackage

// File: rtl/dmc_regs.sv
module dmc_regs
  import dmc_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 5,
  parameter int NUM_MAP = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output dmc_ctrl_t                     ctrl_o,
  output logic [NUM_MAP-1:0][DATA_W-1:0] map_o
);
  localparam int MAP_BASE = NUM_MAP;

  dmc_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == '0) ctrl_q <= dmc_ctrl_t'(wr_data[3:0]);
  end

  for (genvar k = 0; k < NUM_MAP; k++) begin : g_map
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(MAP_BASE + k)) word_q <= wr_data;
    end
    assign map_o[k] = word_q;

    // R2: a hit on this slot's address must land on the next edge
    a_r2_map_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(MAP_BASE + k)) |=> (word_q == $past(wr_data)));
  end

  assign ctrl_o = ctrl_q;

  // R12: addresses between the control word and the map window leave the control word alone
  a_r12_hole_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && wr_addr < ADDR_W'(MAP_BASE)) |=> $stable(ctrl_q));
endmodule

// File: rtl/dmc_mode_dec.sv
module dmc_mode_dec
  import dmc_pkg::*;
#(
  parameter int VA_W = 64
) (
  input  logic [VA_W-1:0] va,
  input  logic            msi,
  input  dmc_ctrl_t       ctrl,
  output dmc_mode_e       mode_o
);
  localparam logic [24:0] BYP_TAG = 25'h1fff800;

  logic hit_byp, hit_leg, hit_tbl;

  always_comb begin
    hit_byp = (ctrl.byp_en || msi) && (va[VA_W-1:39] == BYP_TAG);
    hit_leg = ctrl.xlate_en && !ctrl.tbl_mode && (va[VA_W-1:32] == '0);
    hit_tbl = ctrl.xlate_en &&  ctrl.tbl_mode && (va[VA_W-2:40] == '0);
    if (hit_byp)      mode_o = DMC_BYPASS;
    else if (hit_leg) mode_o = DMC_LEGACY;
    else if (hit_tbl) mode_o = DMC_TABLE;
    else              mode_o = DMC_ERR;
  end
endmodule

// File: rtl/dmc_tbl_sel.sv
module dmc_tbl_sel #(
  parameter int DATA_W  = 64,
  parameter int NUM_MAP = 16,
  parameter int TBL_W   = 5,
  parameter int BUS_W   = 8
) (
  input  logic                           va_msb,
  input  logic [BUS_W-1:0]               bus_id,
  input  logic                           bus_sel,
  input  logic [NUM_MAP-1:0][DATA_W-1:0] map,
  output logic [TBL_W-1:0]               tbl_o
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int WORD_W = $clog2(NUM_MAP);
  localparam int IDX_W  = WORD_W + LANE_W;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word_sel;
  logic [LANE_W-1:0] lane_sel;
  logic [DATA_W-1:0] word;

  always_comb begin
    if (bus_sel) idx = {va_msb, bus_id[IDX_W-2:0]};
    else         idx = {va_msb, bus_id[IDX_W-1:1]};
    word_sel = idx[IDX_W-1:LANE_W];
    lane_sel = idx[LANE_W-1:0];
    word     = map[word_sel];
    tbl_o    = word[lane_sel*8 +: TBL_W];
  end
endmodule

// File: rtl/dma_mode_classifier.sv
module dma_mode_classifier
  import dmc_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PA_W    = 40,
  parameter int BUS_W   = 8,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 5,
  parameter int NUM_MAP = 16,
  parameter int TBL_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_valid,
  input  logic [VA_W-1:0]   va,
  input  logic [BUS_W-1:0]  bus_id,
  input  logic              msi,
  output logic              out_valid,
  output logic [1:0]        mode,
  output logic [PA_W-1:0]   pa,
  output logic [TBL_W-1:0]  tbl_num,
  output logic              err
);
  dmc_ctrl_t                     ctrl;
  logic [NUM_MAP-1:0][DATA_W-1:0] map;
  dmc_mode_e                     mode_d;
  logic [TBL_W-1:0]              tbl_d;

  dmc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_MAP(NUM_MAP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_o(ctrl), .map_o(map)
  );

  dmc_mode_dec #(.VA_W(VA_W)) u_dec (
    .va(va), .msi(msi), .ctrl(ctrl), .mode_o(mode_d)
  );

  dmc_tbl_sel #(.DATA_W(DATA_W), .NUM_MAP(NUM_MAP), .TBL_W(TBL_W), .BUS_W(BUS_W)) u_sel (
    .va_msb(va[VA_W-1]), .bus_id(bus_id), .bus_sel(ctrl.bus_sel), .map(map), .tbl_o(tbl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mode      <= DMC_ERR;
      pa        <= '0;
      tbl_num   <= '0;
      err       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      mode      <= in_valid ? mode_d : DMC_ERR;
      pa        <= (in_valid && mode_d == DMC_BYPASS) ? va[PA_W-1:0] : '0;
      tbl_num   <= (in_valid && mode_d == DMC_TABLE) ? tbl_d : '0;
      err       <= in_valid && mode_d == DMC_ERR;
    end
  end

  // R9: valid follows the request by exactly one cycle
  a_r9_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (mode == 2'd0 && pa == '0 && tbl_num == '0 && !err));
  // R6: error flag only with a valid result of error code
  a_r6_err_code: assert property (@(posedge clk) disable iff (rst)
    err |-> (out_valid && mode == 2'd0));
  // R3: a bypass result carries the low address bits of the request
  a_r3_bypass_pa: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode == 2'd1) |-> (pa == $past(va[PA_W-1:0])));
  // R10: side outputs stay zero outside their modes
  a_r10_pa_zero: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd1) |-> (pa == '0));
  a_r10_tbl_zero: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd3) |-> (tbl_num == '0));
endmodule

// File: tb/dma_mode_classifier_tb.sv
module dma_mode_classifier_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic [63:0] va = '0;
  logic [7:0]  bus_id = '0;
  logic        msi = 1'b0;
  logic        out_valid;
  logic [1:0]  mode;
  logic [39:0] pa;
  logic [4:0]  tbl_num;
  logic        err;

  int checks = 0;
  int errors = 0;

  logic [3:0]  sh_ctrl = '0;
  logic [63:0] sh_map [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mode_classifier u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .va(va), .bus_id(bus_id), .msi(msi),
    .out_valid(out_valid), .mode(mode), .pa(pa), .tbl_num(tbl_num), .err(err)
  );

  function automatic logic [1:0] exp_mode(logic [63:0] a, logic m);
    if ((sh_ctrl[1] || m) && a[63:39] == 25'h1fff800) return 2'd1;
    if (sh_ctrl[0] && !sh_ctrl[2] && a[63:32] == '0) return 2'd2;
    if (sh_ctrl[0] && sh_ctrl[2] && a[62:40] == '0) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [4:0] exp_tbl(logic [63:0] a, logic [7:0] b);
    logic [6:0] ix;
    logic [63:0] w;
    ix = sh_ctrl[3] ? {a[63], b[5:0]} : {a[63], b[6:1]};
    w  = sh_map[ix[6:3]];
    return w[ix[2:0]*8 +: 5];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_shadow(logic [4:0] a, logic [63:0] d);
    if (a == 5'd0) sh_ctrl = d[3:0];
    else if (a >= 5'd16) sh_map[a - 5'd16] = d;
  endtask

  // drive at negedge, result sampled at following negedge
  task automatic step(logic do_wr, logic [4:0] a, logic [63:0] d,
                      logic v, logic [63:0] addr, logic [7:0] b, logic m, string req);
    logic [1:0]  em;
    logic [39:0] ep;
    logic [4:0]  et;
    wr_en = do_wr; wr_addr = a; wr_data = d;
    in_valid = v; va = addr; bus_id = b; msi = m;
    em = v ? exp_mode(addr, m) : 2'd0;
    ep = (em == 2'd1) ? addr[39:0] : '0;
    et = (em == 2'd3) ? exp_tbl(addr, b) : '0;
    if (do_wr) apply_shadow(a, d);
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'(v));
    chk({req, " mode"},  64'(mode), 64'(em));
    chk({req, " pa"},    64'(pa), 64'(ep));
    chk({req, " tbl"},   64'(tbl_num), 64'(et));
    chk({req, " err"},   64'(err), 64'(v && em == 2'd0));
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    step(1'b1, a, d, 1'b0, '0, '0, 1'b0, "R2 write");
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    int seed_dummy;
    for (int i = 0; i < 16; i++) sh_map[i] = '0;
    seed_dummy = $urandom(1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(out_valid), 0);
    chk("R1 mode", 64'(mode), 0);
    chk("R1 err", 64'(err), 0);
    step(0, 0, 0, 1, 64'h0000_0000_0000_1000, 8'h00, 0, "R1 no-config request");

    // R3 bypass by msi with bypass disabled
    step(0, 0, 0, 1, 64'hFFFC_0000_1234_5678, 8'h11, 1, "R3 msi bypass");
    step(0, 0, 0, 1, 64'hFFFC_0000_1234_5678, 8'h11, 0, "R3 bypass off");
    wr(5'd0, 64'h2);
    step(0, 0, 0, 1, 64'hFFFC_007F_FFFF_FFFF, 8'h00, 0, "R3 bypass enabled");
    step(0, 0, 0, 1, 64'hFFFC_8000_0000_0000, 8'h00, 0, "R3 tag mismatch");

    // R4 legacy
    wr(5'd0, 64'h1);
    step(0, 0, 0, 1, 64'h0000_0000_FFFF_0000, 8'h00, 0, "R4 legacy");
    step(0, 0, 0, 1, 64'h0000_0001_0000_0000, 8'h00, 0, "R6 legacy out of range");
    step(0, 0, 0, 1, 64'h8000_0000_0000_0000, 8'h00, 0, "R6 legacy top bit");

    // R5/R7/R8 table mode with mapping words
    wr(5'd16, 64'h1F1E_1D1C_1B1A_1918);
    wr(5'd23, 64'h0102_0304_0506_0708);
    wr(5'd24, 64'hE3E2_E1E0_EFEE_EDEC);
    wr(5'd0, 64'h5);
    step(0, 0, 0, 1, 64'h0000_00FF_FFFF_FFFF, 8'h02, 0, "R7 sel0 lane1 word0");
    step(0, 0, 0, 1, 64'h0000_0000_0000_0000, 8'h7E, 0, "R8 sel0 word7 lane7");
    step(0, 0, 0, 1, 64'h8000_0012_0000_0000, 8'h0A, 0, "R7 va63 picks word8");
    wr(5'd0, 64'hD);
    step(0, 0, 0, 1, 64'h0000_0000_0000_0000, 8'h3B, 0, "R7 sel1 word7 lane3");
    step(0, 0, 0, 1, 64'h8000_0000_0000_0000, 8'h86, 0, "R8 sel1 va63 word8 lane6");
    step(0, 0, 0, 1, 64'h4000_0000_0000_0000, 8'h00, 0, "R6 table bit62");
    step(0, 0, 0, 1, 64'h0000_0100_0000_0000, 8'h00, 0, "R6 table bit40");
    // R6 order: bypass wins over table mode when both enabled
    wr(5'd0, 64'hF);
    step(0, 0, 0, 1, 64'hFFFC_0000_0000_0040, 8'h00, 0, "R6 order bypass first");

    // R12 writes to holes
    wr(5'd5, 64'h0);
    wr(5'd15, 64'h0);
    step(0, 0, 0, 1, 64'hFFFC_0000_0000_0040, 8'h00, 0, "R12 hole kept ctrl");
    step(0, 0, 0, 1, 64'h0000_0000_0000_0000, 8'h02, 0, "R12 hole kept map");

    // R11 same-cycle write and request
    step(1, 5'd0, 64'h0, 1, 64'h0000_0000_0000_0000, 8'h02, 0, "R11 ctrl write same cycle");
    step(0, 0, 0, 1, 64'h0000_0000_0000_0000, 8'h02, 0, "R11 after ctrl write");
    wr(5'd0, 64'hD);
    step(1, 5'd16, 64'h0, 1, 64'h0000_0000_0000_0000, 8'h02, 0, "R11 map write same cycle");
    step(0, 0, 0, 1, 64'h0000_0000_0000_0000, 8'h02, 0, "R11 after map write");

    // R9 idle cycle
    step(0, 0, 0, 0, 64'hFFFC_0000_0000_0040, 8'h00, 1, "R9 idle");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      logic [4:0]  wa;
      int k;
      k = $urandom_range(0, 3);
      a = rnd64();
      if (k == 0) a[63:39] = 25'h1fff800;
      else if (k == 1) a[63:32] = '0;
      else if (k == 2) a[62:40] = '0;
      wa = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(0, 31));
      step(1'($urandom_range(0, 2) == 0), wa, rnd64(), 1'($urandom_range(0, 4) != 0),
           a, 8'($urandom()), 1'($urandom_range(0, 3) == 0), "R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule